// File: doc/BRIEF.md
# Triggered One-Pulse Generator

This block produces one output pulse for each accepted trigger. A trigger clears an internal tick counter to zero and marks the block busy. The output goes active once the counter reaches the delay compare value. It goes inactive when the counter reaches the period top value. At that point the counter halts rather than wrapping, so one trigger gives one pulse. The pulse begins `delay_cmp` ticks after the start and lasts `period_top - delay_cmp` ticks.

One trigger source is chosen at a time. The choices are a software strobe, an external pin, or a trigger line from a neighbouring timer. The external pin is passed through a synchronizer and only its rising edge counts. Both compare values are captured when a trigger is accepted, so changing them while a pulse runs has no effect on that pulse. When retriggering is enabled, a trigger that arrives mid-run restarts the timing from zero. When retriggering is disabled, such a trigger is dropped. After the counter halts, the block waits idle until the next trigger.

Top module: `oneshot_gen`

## Requirements
- R1: An accepted software or timer-line trigger sets `busy` and restarts the count at zero on the next clock edge, so `busy` is seen high one cycle after the trigger is presented.
- R2: Counting the first busy cycle as tick 0, `pulse_out` is high on ticks `delay_cmp` through `period_top-1` and low on every other tick.
- R3: `busy` stays high for exactly `period_top+1` cycles and then falls, and the counter does not wrap.
- R4: When `delay_cmp >= period_top`, `pulse_out` stays low for the whole run, and `busy` still lasts `period_top+1` cycles.
- R5: With `retrig_en` low, a trigger that arrives while `busy` is high is ignored, and the run's timing is unchanged.
- R6: With `retrig_en` high, a trigger that arrives while `busy` is high resets the count to zero on the next edge, and a full new run follows.
- R7: `trig_sel` picks the source: 2'b00 is the software strobe, 2'b01 is the external pin, 2'b10 is the timer line, and 2'b11 means no source. Activity on any source that is not selected starts nothing.
- R8: The external pin passes through two synchronizer flops and an edge detector, so `busy` rises three cycles after the pin goes high. A pin held high gives a single trigger.
- R9: `delay_cmp` and `period_top` are captured at each accepted trigger. Changing them during a run leaves that run's pulse and busy time as they were.
- R10: While reset is asserted and right after it, `busy` and `pulse_out` are low.
- R11: Once a run has ended, the block stays idle with the output low until another trigger arrives, and that trigger starts a complete new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_sel | input | 2 | Trigger source select |
| sw_strobe | input | 1 | Software trigger, one pulse per cycle high |
| ext_trig_in | input | 1 | Asynchronous external trigger pin |
| tmr_trig_in | input | 1 | Synchronous trigger line from another timer |
| retrig_en | input | 1 | Allow a trigger to restart a run in progress |
| delay_cmp | input | CNT_W | Tick at which the output goes active |
| period_top | input | CNT_W | Tick at which the output ends and the counter halts |
| busy | output | 1 | High from the accepted trigger until the counter halts |
| pulse_out | output | 1 | One-shot pulse output |

## Verification
Inputs change on the falling clock edge. Software and timer-line triggers should show `busy` one falling edge later. External triggers should show it three falling edges later. From the first busy falling edge, the bench samples once per cycle and records the tick of the first high output, the number of high ticks, and the number of busy ticks. These are compared with `delay_cmp`, `period_top - delay_cmp` and `period_top + 1`. Mid-run stimuli such as extra triggers or new compare values are applied at a chosen falling edge, and their effect is expected from the following tick on.

// File: rtl/oneshot_gen.sv
`timescale 1ns/1ps
module oneshot_gen #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       trig_sel,
  input  logic             sw_strobe,
  input  logic             ext_trig_in,
  input  logic             tmr_trig_in,
  input  logic             retrig_en,
  input  logic [CNT_W-1:0] delay_cmp,
  input  logic [CNT_W-1:0] period_top,
  output logic             busy,
  output logic             pulse_out
);

  localparam logic [1:0] SEL_SW  = 2'b00;
  localparam logic [1:0] SEL_EXT = 2'b01;
  localparam logic [1:0] SEL_TMR = 2'b10;

  logic [SYNC_STAGES-1:0] ext_sync;
  logic                   ext_prev;
  logic                   ext_rise;
  logic                   trig_pick;
  logic                   accept;
  logic                   busy_q;
  logic [CNT_W-1:0]       cnt_q, cmp_q, top_q;
  logic                   at_top;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_sync <= '0;
      ext_prev <= 1'b0;
    end else begin
      ext_sync <= {ext_sync[SYNC_STAGES-2:0], ext_trig_in};
      ext_prev <= ext_sync[SYNC_STAGES-1];
    end
  end

  assign ext_rise = ext_sync[SYNC_STAGES-1] & ~ext_prev;

  always_comb begin
    case (trig_sel)
      SEL_SW:  trig_pick = sw_strobe;
      SEL_EXT: trig_pick = ext_rise;
      SEL_TMR: trig_pick = tmr_trig_in;
      default: trig_pick = 1'b0;
    endcase
  end

  assign accept = trig_pick & (~busy_q | retrig_en);
  assign at_top = (cnt_q == top_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      cmp_q  <= '0;
      top_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      cmp_q  <= delay_cmp;
      top_q  <= period_top;
    end else if (busy_q) begin
      if (at_top) busy_q <= 1'b0;
      else        cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign busy      = busy_q;
  assign pulse_out = busy_q & (cnt_q >= cmp_q) & (cnt_q < top_q);

  p_start_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy_q && cnt_q == '0);

  p_stop_at_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && at_top && !accept |=> !busy_q && $stable(cnt_q));

  p_ignore_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !retrig_en && !at_top |=> busy_q && cnt_q == CNT_W'($past(cnt_q) + 1'b1));

  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && retrig_en && trig_pick |=> busy_q && cnt_q == '0);

  p_edge_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rise |=> !ext_rise);

  p_hold_cfg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !accept |=> $stable(cmp_q) && $stable(top_q));

  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q && !accept |=> !busy_q && !pulse_out);

endmodule

// File: tb/test_oneshot_gen.sv
`timescale 1ns/1ps
module test_oneshot_gen;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] trig_sel = 2'b00;
  logic sw_strobe = 1'b0, ext_trig_in = 1'b0, tmr_trig_in = 1'b0, retrig_en = 1'b0;
  logic [CNT_W-1:0] delay_cmp = '0, period_top = '0;
  logic busy, pulse_out;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  oneshot_gen #(.CNT_W(CNT_W)) i_oneshot_gen (
    .clk(clk), .rst_n(rst_n), .trig_sel(trig_sel), .sw_strobe(sw_strobe),
    .ext_trig_in(ext_trig_in), .tmr_trig_in(tmr_trig_in), .retrig_en(retrig_en),
    .delay_cmp(delay_cmp), .period_top(period_top), .busy(busy), .pulse_out(pulse_out));

  // {source, delay, top}
  localparam logic [17:0] VEC [0:6] = '{
    {2'd0, 8'd3, 8'd8}, {2'd2, 8'd0, 8'd5}, {2'd1, 8'd2, 8'd6},
    {2'd0, 8'd7, 8'd7}, {2'd0, 8'd9, 8'd4}, {2'd2, 8'd0, 8'd0},
    {2'd0, 8'd1, 8'd20}};

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] src, input int cmp, input int top, input bit rt,
                     input int inj_at, input bit chg,
                     output int lat, output int fh, output int nh, output int nb);
    trig_sel = src; delay_cmp = CNT_W'(cmp); period_top = CNT_W'(top); retrig_en = rt;
    case (src)
      2'd0: sw_strobe = 1'b1;
      2'd1: ext_trig_in = 1'b1;
      2'd2: tmr_trig_in = 1'b1;
      default: ;
    endcase
    fh = -1; nh = 0; nb = 0;
    @(negedge clk); sw_strobe = 1'b0; tmr_trig_in = 1'b0; lat = 1;
    while (!busy && lat < 10) begin @(negedge clk); lat++; end
    for (int i = 0; i < 45; i++) begin
      if (busy) nb++;
      if (pulse_out) begin nh++; if (fh < 0) fh = i; end
      if (i == inj_at) sw_strobe = 1'b1;
      if (chg && i == 1) begin delay_cmp = '0; period_top = CNT_W'(2); end
      @(negedge clk); sw_strobe = 1'b0;
    end
    ext_trig_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lat, fh, nh, nb, cmp, top;
    logic [1:0] src;
    repeat (3) @(negedge clk);
    chk("R10 busy in reset", int'(busy), 0);
    chk("R10 pulse in reset", int'(pulse_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 busy after reset", int'(busy), 0);

    for (int v = 0; v < 7; v++) begin
      src = VEC[v][17:16]; cmp = int'(VEC[v][15:8]); top = int'(VEC[v][7:0]);
      run(src, cmp, top, 1'b0, -1, 1'b0, lat, fh, nh, nb);
      chk((src == 2'd1) ? "R8 ext latency" : "R1 latency", lat, (src == 2'd1) ? 3 : 1);
      chk((cmp < top) ? "R2 width" : "R4 no pulse", nh, (cmp < top) ? top - cmp : 0);
      chk((cmp < top) ? "R2 delay" : "R4 first high", fh, (cmp < top) ? cmp : -1);
      chk("R3 busy length", nb, top + 1);
    end
    chk("R11 idle after run", int'(busy | pulse_out), 0);

    run(2'd0, 4, 10, 1'b0, 5, 1'b0, lat, fh, nh, nb);
    chk("R5 ignored width", nh, 6);
    chk("R5 ignored busy", nb, 11);

    run(2'd0, 4, 10, 1'b1, 5, 1'b0, lat, fh, nh, nb);
    chk("R6 restart high ticks", nh, 8);
    chk("R6 restart busy", nb, 17);

    run(2'd1, 2, 6, 1'b1, -1, 1'b0, lat, fh, nh, nb);
    chk("R8 held pin single run busy", nb, 7);
    chk("R8 held pin width", nh, 4);

    run(2'd0, 3, 9, 1'b0, -1, 1'b1, lat, fh, nh, nb);
    chk("R9 captured width", nh, 6);
    chk("R9 captured busy", nb, 10);

    trig_sel = 2'd0; tmr_trig_in = 1'b1; ext_trig_in = 1'b1;
    @(negedge clk); tmr_trig_in = 1'b0;
    repeat (4) @(negedge clk);
    chk("R7 unselected sources", int'(busy), 0);
    ext_trig_in = 1'b0;
    trig_sel = 2'd3; sw_strobe = 1'b1;
    @(negedge clk); sw_strobe = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 no source", int'(busy), 0);

    run(2'd0, 1, 3, 1'b0, -1, 1'b0, lat, fh, nh, nb);
    chk("R11 rearm busy", nb, 4);
    chk("R11 rearm width", nh, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule